// File: doc/BRIEF.md
# Adaptive Row Auto-Close Decision Unit

A DRAM controller can run an open-page policy that does not keep every row open by default. After a request has been serviced, this unit looks at the requests still waiting in the same direction and decides whether the row just used should be closed at once. The request queue is the read queue for a read and the write queue for a write. If another waiting request targets the same bank on a different row, and no waiting request wants the current row again, closing early hides part of the precharge time. The unit then reports that the row is no longer open and gives the new time at which the bank becomes free.

The controller pulses `start` with the key of the serviced request (direction, rank, bank, row) and the number of entries in the matching queue. It also supplies the bank's current free time and the time at which the row's minimum active period ends. The unit holds queue index 0, because that slot is the request just serviced. It reads one entry per clock through an external indexed read port, from index 1 upward. It stops as soon as both a hit and a conflict have been seen, or when the last entry has been read. A one-cycle `done` pulse carries the decision. Under the plain open policy, or when nothing besides the serviced request is queued, the unit answers "keep open" one cycle after `start`.

Top module: `apc_decider`

## Requirements
- R1: After reset, `done`, `close_row` and `busy` are 0.
- R2: While scanning, `q_sel_wr` equals 1 for a write request and 0 for a read request, and stays constant for the whole scan.
- R3: The scan reads index 1 in the first busy cycle and advances by exactly one index per cycle. It never reads index 0 or any index at or beyond the captured depth.
- R4: An entry whose rank, bank and row all equal those of the request counts as a further hit.
- R5: An entry with the same rank and bank but a different row counts as a conflict. An entry whose rank or bank differs counts as neither.
- R6: The scan ends on the cycle that first holds both a hit and a conflict, or on the last entry. With the scan ending at index k, `done` is high k+1 cycles after the `start` edge.
- R7: `close_row` is 1 (with `done`) only when at least one conflict and no hit were seen.
- R8: On close, `free_out` = max(free time, active-period end) + T_RP. Otherwise, `free_out` equals the free time captured at `start`.
- R9: A depth of 0 or 1 gives "keep open" with `done` one cycle after `start`, and no queue read.
- R10: With `policy_adaptive` = 0 (plain open policy), the unit gives "keep open" one cycle after `start`, whatever the queue holds.
- R11: `done` lasts one cycle. A `start` that arrives while `busy` is 1 is ignored and does not change the decision in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request serviced; capture key and begin |
| policy_adaptive | input | 1 | 1 = adaptive open policy, 0 = plain open |
| req_is_write | input | 1 | Direction of serviced request |
| req_rank | input | RANK_W | Rank of serviced request |
| req_bank | input | BANK_W | Bank of serviced request |
| req_row | input | ROW_W | Row of serviced request |
| q_depth | input | DEPTH_W | Entries in the matching queue, head included |
| free_in | input | TIME_W | Current bank free time |
| tras_in | input | TIME_W | Time at which minimum active period ends |
| q_idx | output | IDX_W | Queue read index |
| q_sel_wr | output | 1 | Queue select: 1 write queue, 0 read queue |
| q_rank | input | RANK_W | Rank of entry at `q_idx` |
| q_bank | input | BANK_W | Bank of entry at `q_idx` |
| q_row | input | ROW_W | Row of entry at `q_idx` |
| busy | output | 1 | Scan in progress |
| done | output | 1 | Decision valid (one cycle) |
| close_row | output | 1 | Row to be closed; valid with `done` |
| free_out | output | TIME_W | New bank free time; valid with `done` |

## Verification
On every cycle, the assertions check the index walk (start at 1, step by one), a stable queue select, the single-cycle `done`, and that `close_row` appears only with `done`. They also check the free-time relation to the captured value: unchanged on keep, later on close. Only the bench scenarios can show that the decision itself is right. That covers hit versus conflict versus unrelated entries, the early stop and its latency, the max() in the free time, and the bypass paths. Each of these is compared against a reference scan computed in the bench over random and directed queue contents.

// File: rtl/apc_pkg.sv
// Shared types for the adaptive auto-close decision unit.
package apc_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } apc_state_e;
endpackage

// File: rtl/apc_match.sv
// apc_match: classifies one queue entry against the serviced request.
// Assumes entry fields are valid whenever 'valid' is high.
module apc_match #(
    parameter int RANK_W = 2,
    parameter int BANK_W = 3,
    parameter int ROW_W  = 14
) (
    input  logic              valid,
    input  logic [RANK_W-1:0] ref_rank,
    input  logic [BANK_W-1:0] ref_bank,
    input  logic [ROW_W-1:0]  ref_row,
    input  logic [RANK_W-1:0] ent_rank,
    input  logic [BANK_W-1:0] ent_bank,
    input  logic [ROW_W-1:0]  ent_row,
    output logic              is_hit,
    output logic              is_conflict
);
    logic same_bank;

    // Compare rank/bank, then split on row equality.
    always_comb begin
        same_bank   = valid && (ent_rank == ref_rank) && (ent_bank == ref_bank);
        is_hit      = same_bank && (ent_row == ref_row);
        is_conflict = same_bank && (ent_row != ref_row);
    end
endmodule

// File: rtl/apc_free_calc.sv
// apc_free_calc: new bank free time when the row is closed early.
// Assumes sums stay within TIME_W bits.
module apc_free_calc #(
    parameter int TIME_W = 32,
    parameter int T_RP   = 12
) (
    input  logic              close,
    input  logic [TIME_W-1:0] free_t,
    input  logic [TIME_W-1:0] tras_t,
    output logic [TIME_W-1:0] free_out
);
    localparam logic [TIME_W-1:0] RP = TIME_W'(T_RP);
    logic [TIME_W-1:0] later;

    // Pick the later of the two times, add precharge when closing.
    always_comb begin
        later    = (tras_t > free_t) ? tras_t : free_t;
        free_out = close ? (later + RP) : free_t;
    end
endmodule

// File: rtl/apc_scan_ctrl.sv
// apc_scan_ctrl: captures the serviced request and walks the queue one
// entry per cycle from index 1. Assumes queue contents stay stable during
// a scan. Starts arriving while busy are ignored.
module apc_scan_ctrl
    import apc_pkg::*;
#(
    parameter int RANK_W  = 2,
    parameter int BANK_W  = 3,
    parameter int ROW_W   = 14,
    parameter int TIME_W  = 32,
    parameter int IDX_W   = 5,
    parameter int DEPTH_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               policy_adaptive,
    input  logic               req_is_write,
    input  logic [RANK_W-1:0]  req_rank,
    input  logic [BANK_W-1:0]  req_bank,
    input  logic [ROW_W-1:0]   req_row,
    input  logic [DEPTH_W-1:0] q_depth,
    input  logic [TIME_W-1:0]  free_in,
    input  logic [TIME_W-1:0]  tras_in,
    input  logic               ent_hit,
    input  logic               ent_conflict,
    output logic [RANK_W-1:0]  key_rank,
    output logic [BANK_W-1:0]  key_bank,
    output logic [ROW_W-1:0]   key_row,
    output logic [TIME_W-1:0]  free_l,
    output logic [TIME_W-1:0]  tras_l,
    output logic [IDX_W-1:0]   idx,
    output logic               sel_wr,
    output logic               busy,
    output logic               done,
    output logic               close_q
);
    apc_state_e         st;
    logic [DEPTH_W-1:0] depth_l;
    logic               hit_f, conf_f;
    logic               hit_n, conf_n, last, stop;

    // Next flags and scan-end condition for the entry read this cycle.
    always_comb begin
        hit_n  = hit_f  | ent_hit;
        conf_n = conf_f | ent_conflict;
        last   = (DEPTH_W'(idx) == depth_l - DEPTH_W'(1));
        stop   = (hit_n && conf_n) || last;
    end

    // Scan state machine with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            depth_l  <= '0;
            hit_f    <= 1'b0;
            conf_f   <= 1'b0;
            idx      <= '0;
            sel_wr   <= 1'b0;
            done     <= 1'b0;
            close_q  <= 1'b0;
            key_rank <= '0;
            key_bank <= '0;
            key_row  <= '0;
            free_l   <= '0;
            tras_l   <= '0;
        end else begin
            done    <= 1'b0;
            close_q <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        key_rank <= req_rank;
                        key_bank <= req_bank;
                        key_row  <= req_row;
                        free_l   <= free_in;
                        tras_l   <= tras_in;
                        sel_wr   <= req_is_write;
                        depth_l  <= q_depth;
                        hit_f    <= 1'b0;
                        conf_f   <= 1'b0;
                        if (!policy_adaptive || q_depth <= DEPTH_W'(1)) begin
                            done <= 1'b1;
                        end else begin
                            st  <= ST_SCAN;
                            idx <= IDX_W'(1);
                        end
                    end
                end
                ST_SCAN: begin
                    hit_f  <= hit_n;
                    conf_f <= conf_n;
                    if (stop) begin
                        st      <= ST_IDLE;
                        done    <= 1'b1;
                        close_q <= !hit_n && conf_n;
                    end else begin
                        idx <= idx + IDX_W'(1);
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy = (st == ST_SCAN);
endmodule

// File: rtl/apc_decider.sv
// apc_decider: top of the adaptive auto-close decision unit. Scans the
// same-direction queue through an external combinational read port and
// reports whether to close the row and the resulting bank free time.
// Assumes q_rank/q_bank/q_row reflect q_idx/q_sel_wr in the same cycle.
module apc_decider #(
    parameter int RANK_W   = 2,
    parameter int BANK_W   = 3,
    parameter int ROW_W    = 14,
    parameter int TIME_W   = 32,
    parameter int Q_DEPTH  = 32,
    parameter int T_RP     = 12,
    localparam int IDX_W   = $clog2(Q_DEPTH),
    localparam int DEPTH_W = $clog2(Q_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               policy_adaptive,
    input  logic               req_is_write,
    input  logic [RANK_W-1:0]  req_rank,
    input  logic [BANK_W-1:0]  req_bank,
    input  logic [ROW_W-1:0]   req_row,
    input  logic [DEPTH_W-1:0] q_depth,
    input  logic [TIME_W-1:0]  free_in,
    input  logic [TIME_W-1:0]  tras_in,
    output logic [IDX_W-1:0]   q_idx,
    output logic               q_sel_wr,
    input  logic [RANK_W-1:0]  q_rank,
    input  logic [BANK_W-1:0]  q_bank,
    input  logic [ROW_W-1:0]   q_row,
    output logic               busy,
    output logic               done,
    output logic               close_row,
    output logic [TIME_W-1:0]  free_out
);
    logic [RANK_W-1:0] key_rank;
    logic [BANK_W-1:0] key_bank;
    logic [ROW_W-1:0]  key_row;
    logic [TIME_W-1:0] free_l, tras_l;
    logic              ent_hit, ent_conflict, close_q;

    apc_match #(.RANK_W(RANK_W), .BANK_W(BANK_W), .ROW_W(ROW_W)) u_match (
        .valid(busy), .ref_rank(key_rank), .ref_bank(key_bank), .ref_row(key_row),
        .ent_rank(q_rank), .ent_bank(q_bank), .ent_row(q_row),
        .is_hit(ent_hit), .is_conflict(ent_conflict)
    );

    apc_scan_ctrl #(
        .RANK_W(RANK_W), .BANK_W(BANK_W), .ROW_W(ROW_W),
        .TIME_W(TIME_W), .IDX_W(IDX_W), .DEPTH_W(DEPTH_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .policy_adaptive(policy_adaptive),
        .req_is_write(req_is_write), .req_rank(req_rank), .req_bank(req_bank),
        .req_row(req_row), .q_depth(q_depth), .free_in(free_in), .tras_in(tras_in),
        .ent_hit(ent_hit), .ent_conflict(ent_conflict),
        .key_rank(key_rank), .key_bank(key_bank), .key_row(key_row),
        .free_l(free_l), .tras_l(tras_l), .idx(q_idx), .sel_wr(q_sel_wr),
        .busy(busy), .done(done), .close_q(close_q)
    );

    apc_free_calc #(.TIME_W(TIME_W), .T_RP(T_RP)) u_free (
        .close(close_q), .free_t(free_l), .tras_t(tras_l), .free_out(free_out)
    );

    assign close_row = close_q;
endmodule

// File: rtl/apc_decider_chk.sv
// apc_decider_chk: cycle-level properties of apc_decider, bound below.
module apc_decider_chk #(
    parameter int IDX_W  = 5,
    parameter int TIME_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              close_row,
    input logic [IDX_W-1:0]  q_idx,
    input logic              q_sel_wr,
    input logic [TIME_W-1:0] free_out,
    input logic [TIME_W-1:0] free_l
);
    // R11: done is a single-cycle pulse
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7: close only reported together with done
    a_r7_close_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        close_row |-> done);
    // R3: first busy cycle reads index 1
    a_r3_idx_first: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !$past(busy)) |-> (q_idx == IDX_W'(1)));
    // R3: index advances by one per busy cycle
    a_r3_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (q_idx == $past(q_idx) + IDX_W'(1)));
    // R2: queue select constant during a scan
    a_r2_dir_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(q_sel_wr));
    // R8: keep leaves free time unchanged
    a_r8_keep_time: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !close_row) |-> (free_out == free_l));
    // R8: close pushes free time out
    a_r8_close_later: assert property (@(posedge clk) disable iff (!rst_n)
        (done && close_row) |-> (free_out > free_l));
endmodule

bind apc_decider apc_decider_chk #(.IDX_W(IDX_W), .TIME_W(TIME_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .close_row(close_row),
    .q_idx(q_idx), .q_sel_wr(q_sel_wr), .free_out(free_out), .free_l(free_l)
);

// File: tb/apc_decider_tb.sv
module apc_decider_tb;
    localparam int RANK_W = 2, BANK_W = 3, ROW_W = 14, TIME_W = 32;
    localparam int Q_DEPTH = 32, T_RP = 12;
    localparam int IDX_W = $clog2(Q_DEPTH), DEPTH_W = $clog2(Q_DEPTH + 1);

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, policy_adaptive = 1'b0, req_is_write = 1'b0;
    logic [RANK_W-1:0] req_rank = '0;
    logic [BANK_W-1:0] req_bank = '0;
    logic [ROW_W-1:0]  req_row = '0;
    logic [DEPTH_W-1:0] q_depth = '0;
    logic [TIME_W-1:0] free_in = '0, tras_in = '0;
    logic [IDX_W-1:0] q_idx;
    logic q_sel_wr, busy, done, close_row;
    logic [TIME_W-1:0] free_out;
    logic [RANK_W-1:0] q_rank;
    logic [BANK_W-1:0] q_bank;
    logic [ROW_W-1:0]  q_row;

    logic [RANK_W-1:0] rq_rank [Q_DEPTH], wq_rank [Q_DEPTH];
    logic [BANK_W-1:0] rq_bank [Q_DEPTH], wq_bank [Q_DEPTH];
    logic [ROW_W-1:0]  rq_row  [Q_DEPTH], wq_row  [Q_DEPTH];

    int checks = 0, errors = 0;

    always #10 clk = ~clk;  // 50 MHz

    // Combinational queue read port model
    assign q_rank = q_sel_wr ? wq_rank[q_idx] : rq_rank[q_idx];
    assign q_bank = q_sel_wr ? wq_bank[q_idx] : rq_bank[q_idx];
    assign q_row  = q_sel_wr ? wq_row[q_idx]  : rq_row[q_idx];

    apc_decider #(.RANK_W(RANK_W), .BANK_W(BANK_W), .ROW_W(ROW_W), .TIME_W(TIME_W),
                  .Q_DEPTH(Q_DEPTH), .T_RP(T_RP)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .policy_adaptive(policy_adaptive),
        .req_is_write(req_is_write), .req_rank(req_rank), .req_bank(req_bank),
        .req_row(req_row), .q_depth(q_depth), .free_in(free_in), .tras_in(tras_in),
        .q_idx(q_idx), .q_sel_wr(q_sel_wr), .q_rank(q_rank), .q_bank(q_bank),
        .q_row(q_row), .busy(busy), .done(done), .close_row(close_row),
        .free_out(free_out)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference decision: latency, close flag, new free time
    function automatic void ref_scan(input bit adapt, input bit wr, input int depth,
                                     input int rk, input int bk, input int rw,
                                     input longint fr, input longint tr,
                                     output int lat, output bit cl, output longint fo);
        bit h = 0, c = 0;
        lat = 1;
        if (adapt && depth > 1) begin
            for (int i = 1; i < depth; i++) begin
                int er = wr ? wq_rank[i] : rq_rank[i];
                int eb = wr ? wq_bank[i] : rq_bank[i];
                int ew = wr ? wq_row[i]  : rq_row[i];
                if (er == rk && eb == bk) begin
                    if (ew == rw) h = 1; else c = 1;  // R4 / R5
                end
                lat = i + 1;
                if (h && c) break;                    // R6
            end
        end
        cl = !h && c;                                 // R7
        fo = cl ? (((tr > fr) ? tr : fr) + T_RP) : fr; // R8
    endfunction

    task automatic fill_rand(input bit wr, input int span);
        for (int i = 0; i < Q_DEPTH; i++) begin
            if (wr) begin
                wq_rank[i] = RANK_W'($urandom_range(0, 1));
                wq_bank[i] = BANK_W'($urandom_range(0, span));
                wq_row[i]  = ROW_W'($urandom_range(0, 2));
            end else begin
                rq_rank[i] = RANK_W'($urandom_range(0, 1));
                rq_bank[i] = BANK_W'($urandom_range(0, span));
                rq_row[i]  = ROW_W'($urandom_range(0, 2));
            end
        end
    endtask

    task automatic set_ent(input bit wr, input int i, input int rk, input int bk, input int rw);
        if (wr) begin wq_rank[i] = RANK_W'(rk); wq_bank[i] = BANK_W'(bk); wq_row[i] = ROW_W'(rw); end
        else    begin rq_rank[i] = RANK_W'(rk); rq_bank[i] = BANK_W'(bk); rq_row[i] = ROW_W'(rw); end
    endtask

    // Run one decision and compare against the reference.
    task automatic run_case(input bit adapt, input bit wr, input int depth,
                            input int rk, input int bk, input int rw,
                            input longint fr, input longint tr, input bit inject);
        int elat, cnt;
        bit ecl, idx_ok, dir_ok;
        longint efo;
        ref_scan(adapt, wr, depth, rk, bk, rw, fr, tr, elat, ecl, efo);
        @(negedge clk);
        policy_adaptive = adapt; req_is_write = wr; q_depth = DEPTH_W'(depth);
        req_rank = RANK_W'(rk); req_bank = BANK_W'(bk); req_row = ROW_W'(rw);
        free_in = TIME_W'(fr); tras_in = TIME_W'(tr); start = 1'b1;
        @(posedge clk); @(negedge clk);
        start = 1'b0;
        cnt = 1; idx_ok = 1; dir_ok = 1;
        while (!done && cnt < 100) begin
            if (busy) begin
                if (int'(q_idx) != cnt || cnt >= depth) idx_ok = 0;
                if (q_sel_wr != wr) dir_ok = 0;
            end
            if (inject && cnt == 1) begin
                // R11: start during scan with bypass settings; must be ignored
                start = 1'b1; policy_adaptive = 1'b0; q_depth = '0;
                free_in = 32'd7; tras_in = 32'd9;
            end else begin
                start = 1'b0;
            end
            @(posedge clk); @(negedge clk);
            cnt++;
        end
        start = 1'b0;
        check(done, "R6 done seen", done, 1);
        check(cnt == elat, "R6 latency", cnt, elat);
        check(idx_ok, "R3 index walk", idx_ok, 1);
        check(dir_ok, "R2 queue select", dir_ok, 1);
        check(close_row == ecl, "R7 close decision", close_row, ecl);
        check(free_out == TIME_W'(efo), "R8 free time", free_out, efo);
        @(negedge clk);
        check(!done, "R11 done one cycle", done, 0);
        check(!busy, "R11 idle after done", busy, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < Q_DEPTH; i++) begin set_ent(0, i, 3, 7, 100); set_ent(1, i, 3, 7, 100); end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(!done && !busy && !close_row, "R1 reset outputs", {done, busy, close_row}, 0);
        rst_n = 1'b1;

        // R9: depth 0 and 1 keep open immediately
        set_ent(0, 0, 0, 0, 5);
        run_case(1, 0, 0, 0, 0, 5, 100, 200, 0);
        run_case(1, 0, 1, 0, 0, 5, 100, 200, 0);
        // R5: conflict only -> close; tras later than free (R8 max)
        set_ent(0, 1, 0, 0, 6);
        set_ent(0, 2, 1, 0, 6);
        run_case(1, 0, 3, 0, 0, 5, 100, 200, 0);
        // R10: plain open policy keeps open despite conflict
        run_case(0, 0, 3, 0, 0, 5, 100, 200, 0);
        // R4: conflict then hit -> keep, stop early at index 2
        set_ent(0, 2, 0, 0, 5);
        set_ent(0, 3, 0, 0, 9);
        run_case(1, 0, 6, 0, 0, 5, 300, 50, 0);
        // R5: different rank/bank only -> keep, full scan
        for (int i = 1; i < 8; i++) set_ent(1, i, i % 2, 1 + (i % 3), 5);
        run_case(1, 1, 8, 0, 0, 5, 40, 10, 0);
        // R4: hit only on write queue -> keep, full length scan
        set_ent(1, 7, 0, 0, 5);
        run_case(1, 1, 8, 0, 0, 5, 40, 10, 0);
        // R8: conflict at last full-depth entry, free later than tras
        for (int i = 1; i < Q_DEPTH; i++) set_ent(1, i, 2, 2, 5);
        set_ent(1, Q_DEPTH - 1, 0, 0, 1);
        run_case(1, 1, Q_DEPTH, 0, 0, 5, 500, 20, 0);
        // R11: start during scan ignored
        set_ent(0, 1, 2, 2, 2);
        set_ent(0, 2, 0, 0, 6);
        set_ent(0, 3, 1, 1, 1);
        run_case(1, 0, 4, 0, 0, 5, 100, 150, 1);

        // Random mix
        for (int n = 0; n < 60; n++) begin
            bit wr = 1'($urandom_range(0, 1));
            fill_rand(wr, 1);
            run_case(($urandom_range(0, 7) != 0), wr, $urandom_range(0, Q_DEPTH),
                     $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 2),
                     $urandom_range(0, 1000), $urandom_range(0, 1000),
                     ($urandom_range(0, 5) == 0));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule